// File: doc/BRIEF.md
# Byte ALU with Status Flag Register

This block is the arithmetic and logic datapath of a small load/store processor core. Every cycle it takes one operation request: an operation code, two byte operands and a bit index. Within the same cycle it returns a byte result, a result write strobe, a mask of the status flags the operation touches and the merged flag vector those flags will produce. A status register inside the block loads the merged vector at the next clock edge. Flags that an operation does not name keep their stored value. Carry-in and the previous zero flag come from the stored status, so chains of multi-byte adds, subtracts and compares work across requests.

One more path adds or subtracts a 6-bit unsigned constant to or from a byte pair, treated as one 16-bit value, over two cycles. The low byte is returned in the cycle of the request and the high byte in the cycle after it. The flags are set from the whole 16-bit result. While the second cycle runs, `busy` is high and a new request is not taken.

Top module: `alu8_core`

## Requirements
- R1: Flag vector bits are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. The op_sel codes are: 0 add, 1 add-carry, 2 sub, 3 sub-carry, 4 compare, 5 compare-carry, 6 and, 7 or, 8 xor, 9 one's complement, 10 negate, 11 increment, 12 decrement, 13 shift-left, 14 shift-right, 15 rotate-left, 16 rotate-right, 17 arithmetic-shift-right, 18 nibble-swap, 19 flag-set, 20 flag-clear, 21 bit-to-T, 22 word-add, 23 word-sub. Codes 24 to 31 write nothing and update no flag. After reset sreg is 0, busy is 0 and res_we is 0.
- R2: Add, add-carry, sub, sub-carry and negate (0 minus opa) return the byte result with res_we high and update H, S, V, N, Z, C (mask 0x3F). C is the carry out of bit 7 or the borrow into it. H is the carry out of bit 3 or the borrow into bit 4. V is signed overflow. Carry-in is the stored C for the carry forms and 0 otherwise.
- R3: Compare and compare-carry compute opa-opb (minus stored C for compare-carry) and update the same flags as subtract, with res_we low.
- R4: For sub-carry and compare-carry, Z becomes 1 only if the result is zero and the stored Z was 1.
- R5: And, or and xor return the bitwise result and update S, V, N, Z (mask 0x1E). V is cleared and C is kept.
- R6: One's complement returns 0xFF-opa with C=1 and V=0 (mask 0x1F). Increment and decrement return opa±1 with mask 0x1E, so C is kept. V is set only when increment starts from 0x7F or decrement starts from 0x80.
- R7: Shift-left and shift-right fill with 0. Rotate-left and rotate-right shift the stored C in at the vacated end. Arithmetic shift right keeps bit 7. In all five the bit shifted out becomes C, V = N xor new C, and the mask is 0x1F.
- R8: Nibble swap exchanges opa[7:4] with opa[3:0], writes the result and updates no flag.
- R9: Whenever an operation updates N, the new S equals the new N xor the new V.
- R10: Flag-set and flag-clear force sreg bit bit_sel to 1 or 0. Bit-to-T copies opa[bit_sel] into T. None of the three raises res_we.
- R11: On a word request, res is the low byte of pair_lo±imm6, with res_we high, res_hi_byte low and no flag update. In the next cycle res is the high byte of the 16-bit result, with res_we and res_hi_byte high. That cycle updates S, V, N, Z, C (mask 0x1F) from the 16-bit result, and Z covers all 16 bits.
- R12: busy is high only in the second word cycle, and a request made in that cycle is ignored.
- R13: At each clock edge sreg loads flag_new. Bits outside flag_upd keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request this cycle |
| op_sel | input | 5 | Operation code |
| opa | input | 8 | First operand (destination register value) |
| opb | input | 8 | Second operand or immediate |
| bit_sel | input | 3 | Bit index for flag and bit operations |
| pair_lo | input | 8 | Low byte of the register pair for word ops |
| pair_hi | input | 8 | High byte of the register pair for word ops |
| imm6 | input | 6 | Unsigned constant for word ops |
| res | output | 8 | Result byte |
| res_we | output | 1 | Result is to be written back |
| res_hi_byte | output | 1 | Result is the high byte of a word op |
| busy | output | 1 | Second cycle of a word op |
| flag_upd | output | 8 | Flags updated by the current cycle |
| flag_new | output | 8 | Status vector loaded at the next edge |
| sreg | output | 8 | Stored status flags |

## Verification
The stored status is the block's only long-lived state, so a wrong carry or zero bit stays hidden until a carry form, a rotate or a chained compare reads it. Tracking a shadow status on every request therefore exposes it at the latest one request later, when flag_new or the result of that reader goes wrong. A wrong word-path state shows in the very next cycle as a wrong high byte, a missing res_hi_byte or busy held for a second cycle. A request taken during busy shows as a changed interrupt bit in sreg.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;
  localparam int FLAG_W = 8;

  localparam logic [FLAG_W-1:0] MASK_ARITH = 8'h3F;
  localparam logic [FLAG_W-1:0] MASK_LOGIC = 8'h1E;
  localparam logic [FLAG_W-1:0] MASK_SHIFT = 8'h1F;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,
    OP_CPC  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_COM  = 5'd9,
    OP_NEG  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_LSL  = 5'd13,
    OP_LSR  = 5'd14,
    OP_ROL  = 5'd15,
    OP_ROR  = 5'd16,
    OP_ASR  = 5'd17,
    OP_SWAP = 5'd18,
    OP_FSET = 5'd19,
    OP_FCLR = 5'd20,
    OP_BST  = 5'd21,
    OP_WADD = 5'd22,
    OP_WSUB = 5'd23
  } alu_op_e;

endpackage

// File: rtl/alu8_rst_sync.sv
module alu8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  input  logic          zchain,
  input  logic          zprev,
  output logic [DW-1:0] r,
  output logic          c,
  output logic          h,
  output logic          v,
  output logic          z
);
  localparam int HALF = DW / 2;
  localparam int MSB  = DW - 1;

  logic [DW-1:0] b_eff;
  logic          c_eff;
  logic [DW:0]   full_sum;
  logic [HALF:0] nib_sum;

  // subtraction is a + ~b + ~borrow; carries are inverted back to borrows
  always_comb begin
    b_eff    = sub ? ~b : b;
    c_eff    = sub ? ~cin : cin;
    full_sum = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
    nib_sum  = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, c_eff};
    r        = full_sum[DW-1:0];
    c        = full_sum[DW] ^ sub;
    h        = nib_sum[HALF] ^ sub;
    v        = (a[MSB] == b_eff[MSB]) && (r[MSB] != a[MSB]);
    z        = (r == '0) && (!zchain || zprev);
  end
endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] r,
  output logic          c_out,
  output logic          v_out
);
  localparam int HALF = DW / 2;
  localparam int MSB  = DW - 1;
  localparam logic [DW-1:0] ONE     = DW'(1);
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};

  always_comb begin
    r     = a;
    c_out = cin;
    v_out = 1'b0;
    case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_COM: begin
        r     = ~a;
        c_out = 1'b1;
      end
      OP_INC: begin
        r     = a + ONE;
        v_out = (a == MAX_POS);
      end
      OP_DEC: begin
        r     = a - ONE;
        v_out = (a == MIN_NEG);
      end
      OP_LSL: begin
        r     = {a[MSB-1:0], 1'b0};
        c_out = a[MSB];
        v_out = r[MSB] ^ c_out;
      end
      OP_LSR: begin
        r     = {1'b0, a[MSB:1]};
        c_out = a[0];
        v_out = r[MSB] ^ c_out;
      end
      OP_ROL: begin
        r     = {a[MSB-1:0], cin};
        c_out = a[MSB];
        v_out = r[MSB] ^ c_out;
      end
      OP_ROR: begin
        r     = {cin, a[MSB:1]};
        c_out = a[0];
        v_out = r[MSB] ^ c_out;
      end
      OP_ASR: begin
        r     = {a[MSB], a[MSB:1]};
        c_out = a[0];
        v_out = r[MSB] ^ c_out;
      end
      OP_SWAP: r = {a[HALF-1:0], a[MSB:HALF]};
      default: r = a;
    endcase
  end
endmodule

// File: rtl/alu8_word.sv
module alu8_word #(
  parameter int DW    = 8,
  parameter int IMM_W = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sub,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  input  logic [IMM_W-1:0] imm,
  output logic          busy,
  output logic [DW-1:0] r_lo,
  output logic [DW-1:0] r_hi,
  output logic          wc,
  output logic          wz,
  output logic          wn,
  output logic          wv
);
  localparam int MSB = DW - 1;

  logic          busy_q, busy_d;
  logic          sub_q, sub_d;
  logic [DW-1:0] hi_q, hi_d;
  logic          cy_q, cy_d;
  logic          zlo_q, zlo_d;
  logic          lo_cy;
  logic          hi_cy;
  logic [DW:0]   imm_ext;

  // first cycle: low byte and its carry/borrow
  always_comb begin
    imm_ext = {{(DW+1-IMM_W){1'b0}}, imm};
    if (sub) {lo_cy, r_lo} = {1'b0, lo} - imm_ext;
    else     {lo_cy, r_lo} = {1'b0, lo} + imm_ext;
  end

  // next state
  always_comb begin
    busy_d = start;
    sub_d  = sub_q;
    hi_d   = hi_q;
    cy_d   = cy_q;
    zlo_d  = zlo_q;
    if (start) begin
      sub_d = sub;
      hi_d  = hi;
      cy_d  = lo_cy;
      zlo_d = (r_lo == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sub_q  <= 1'b0;
      hi_q   <= '0;
      cy_q   <= 1'b0;
      zlo_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (start) begin
        sub_q <= sub_d;
        hi_q  <= hi_d;
        cy_q  <= cy_d;
        zlo_q <= zlo_d;
      end
    end
  end

  // second cycle: high byte and 16-bit flags
  always_comb begin
    if (sub_q) {hi_cy, r_hi} = {1'b0, hi_q} - {{DW{1'b0}}, cy_q};
    else       {hi_cy, r_hi} = {1'b0, hi_q} + {{DW{1'b0}}, cy_q};
    wc = hi_cy;
    wz = zlo_q && (r_hi == '0);
    wn = r_hi[MSB];
    wv = sub_q ? (hi_q[MSB] && !r_hi[MSB]) : (!hi_q[MSB] && r_hi[MSB]);
  end

  assign busy = busy_q;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IMM_W = 6,
  localparam int BSW  = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        op_sel,
  input  logic [DW-1:0]     opa,
  input  logic [DW-1:0]     opb,
  input  logic [BSW-1:0]    bit_sel,
  input  logic [DW-1:0]     pair_lo,
  input  logic [DW-1:0]     pair_hi,
  input  logic [IMM_W-1:0]  imm6,
  output logic [DW-1:0]     res,
  output logic              res_we,
  output logic              res_hi_byte,
  output logic              busy,
  output logic [FLAG_W-1:0] flag_upd,
  output logic [FLAG_W-1:0] flag_new,
  output logic [FLAG_W-1:0] sreg
);
  localparam int MSB = DW - 1;

  alu_op_e op;
  logic    rst_n_int;
  logic    issue;

  logic [DW-1:0] ar_a, ar_b, ar_r;
  logic          ar_sub, ar_cin, ar_zchain;
  logic          ar_c, ar_h, ar_v, ar_z;

  logic [DW-1:0] un_r;
  logic          un_c, un_v;

  logic          w_start, w_sub, w_busy;
  logic [DW-1:0] w_rlo, w_rhi;
  logic          w_c, w_z, w_n, w_v;

  logic [FLAG_W-1:0] sreg_q;
  logic [FLAG_W-1:0] calc;
  logic [FLAG_W-1:0] upd;
  logic [DW-1:0]     res_c;
  logic              we_c, hib_c, flag_op;
  logic              sreg_en;

  assign op    = alu_op_e'(op_sel);
  assign issue = op_valid && !w_busy;

  alu8_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // operand steering for the add/subtract unit
  always_comb begin
    ar_a      = (op == OP_NEG) ? '0  : opa;
    ar_b      = (op == OP_NEG) ? opa : opb;
    ar_sub    = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) ||
                (op == OP_CPC) || (op == OP_NEG);
    ar_zchain = (op == OP_SBC) || (op == OP_CPC);
    ar_cin    = ((op == OP_ADC) || ar_zchain) && sreg_q[FL_C];
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .a      (ar_a),
    .b      (ar_b),
    .cin    (ar_cin),
    .sub    (ar_sub),
    .zchain (ar_zchain),
    .zprev  (sreg_q[FL_Z]),
    .r      (ar_r),
    .c      (ar_c),
    .h      (ar_h),
    .v      (ar_v),
    .z      (ar_z)
  );

  alu8_unary #(.DW(DW)) u_unary (
    .op    (op),
    .a     (opa),
    .b     (opb),
    .cin   (sreg_q[FL_C]),
    .r     (un_r),
    .c_out (un_c),
    .v_out (un_v)
  );

  assign w_start = issue && ((op == OP_WADD) || (op == OP_WSUB));
  assign w_sub   = (op == OP_WSUB);

  alu8_word #(.DW(DW), .IMM_W(IMM_W)) u_word (
    .clk   (clk),
    .rst_n (rst_n_int),
    .start (w_start),
    .sub   (w_sub),
    .lo    (pair_lo),
    .hi    (pair_hi),
    .imm   (imm6),
    .busy  (w_busy),
    .r_lo  (w_rlo),
    .r_hi  (w_rhi),
    .wc    (w_c),
    .wz    (w_z),
    .wn    (w_n),
    .wv    (w_v)
  );

  // decode: result, write strobe, flag values and flag mask
  always_comb begin
    res_c   = '0;
    we_c    = 1'b0;
    hib_c   = 1'b0;
    upd     = '0;
    calc    = sreg_q;
    flag_op = 1'b0;
    if (w_busy) begin
      res_c      = w_rhi;
      we_c       = 1'b1;
      hib_c      = 1'b1;
      upd        = MASK_SHIFT;
      calc[FL_C] = w_c;
      calc[FL_Z] = w_z;
      calc[FL_N] = w_n;
      calc[FL_V] = w_v;
    end else if (op_valid) begin
      case (op)
        OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_CMP, OP_CPC: begin
          res_c      = ar_r;
          we_c       = (op != OP_CMP) && (op != OP_CPC);
          upd        = MASK_ARITH;
          calc[FL_H] = ar_h;
          calc[FL_V] = ar_v;
          calc[FL_N] = ar_r[MSB];
          calc[FL_Z] = ar_z;
          calc[FL_C] = ar_c;
        end
        OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
          res_c      = un_r;
          we_c       = 1'b1;
          upd        = MASK_LOGIC;
          calc[FL_V] = un_v;
          calc[FL_N] = un_r[MSB];
          calc[FL_Z] = (un_r == '0);
        end
        OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
          res_c      = un_r;
          we_c       = 1'b1;
          upd        = MASK_SHIFT;
          calc[FL_V] = un_v;
          calc[FL_N] = un_r[MSB];
          calc[FL_Z] = (un_r == '0);
          calc[FL_C] = un_c;
        end
        OP_SWAP: begin
          res_c = un_r;
          we_c  = 1'b1;
        end
        OP_FSET: begin
          flag_op = 1'b1;
          upd     = FLAG_W'(1) << bit_sel;
          calc    = '1;
        end
        OP_FCLR: begin
          flag_op = 1'b1;
          upd     = FLAG_W'(1) << bit_sel;
          calc    = '0;
        end
        OP_BST: begin
          flag_op    = 1'b1;
          upd        = FLAG_W'(1) << FL_T;
          calc[FL_T] = opa[bit_sel];
        end
        OP_WADD, OP_WSUB: begin
          res_c = w_rlo;
          we_c  = 1'b1;
        end
        default: begin
          res_c = '0;
        end
      endcase
    end
    if (!flag_op) calc[FL_S] = calc[FL_N] ^ calc[FL_V];
  end

  assign flag_new = (sreg_q & ~upd) | (calc & upd);
  assign sreg_en  = |upd;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      sreg_q <= '0;
    end else if (sreg_en) begin
      sreg_q <= flag_new;
    end
  end

  assign res         = res_c;
  assign res_we      = we_c;
  assign res_hi_byte = hib_c;
  assign busy        = w_busy;
  assign flag_upd    = upd;
  assign sreg        = sreg_q;

  // issue is only used to gate the word path start
  logic unused_issue;
  assign unused_issue = issue;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [4:0] op_sel,
  input logic       res_we,
  input logic       res_hi_byte,
  input logic       busy,
  input logic [7:0] flag_upd,
  input logic [7:0] flag_new,
  input logic [7:0] sreg
);
  logic take;
  assign take = op_valid && !busy;

  assert_hold_unmasked_R13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((sreg ^ $past(sreg)) & ~$past(flag_upd)) == 8'h00));

  assert_load_new_R13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((sreg ^ $past(flag_new)) & $past(flag_upd)) == 8'h00));

  assert_s_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd[FL_N] && flag_upd[FL_S]) |->
      (flag_new[FL_S] == (flag_new[FL_N] ^ flag_new[FL_V])));

  assert_cmp_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (op_sel == OP_CMP || op_sel == OP_CPC)) |-> (!res_we && flag_upd == 8'h3F));

  assert_swap_noflags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_sel == OP_SWAP) |-> (res_we && flag_upd == 8'h00));

  assert_flagop_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (op_sel == OP_FSET || op_sel == OP_FCLR || op_sel == OP_BST)) |->
      ($countones(flag_upd) == 1 && !res_we));

  assert_incdec_keepc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (op_sel == OP_INC || op_sel == OP_DEC)) |-> !flag_upd[FL_C]);

  assert_word_second_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (op_sel == OP_WADD || op_sel == OP_WSUB)) |=>
      (busy && res_we && res_hi_byte && flag_upd == 8'h1F));

  assert_busy_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  assert_spare_codes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_sel >= 5'd24) |-> (!res_we && flag_upd == 8'h00));
endmodule

bind alu8_core alu8_core_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .op_sel      (op_sel),
  .res_we      (res_we),
  .res_hi_byte (res_hi_byte),
  .busy        (busy),
  .flag_upd    (flag_upd),
  .flag_new    (flag_new),
  .sreg        (sreg)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [4:0] op_sel;
  logic [7:0] opa, opb;
  logic [2:0] bit_sel;
  logic [7:0] pair_lo, pair_hi;
  logic [5:0] imm6;
  logic [7:0] res;
  logic       res_we, res_hi_byte, busy;
  logic [7:0] flag_upd, flag_new, sreg;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [7:0] exp_sreg;

  localparam logic [7:0] BL [20] = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h7F, 8'h80,
    8'h81, 8'hFE, 8'hFF, 8'h55, 8'hAA, 8'h08, 8'h09, 8'h40, 8'h3C, 8'hC3, 8'h77,
    8'h88, 8'h99};

  alu8_core uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .opa(opa),
    .opb(opb), .bit_sel(bit_sel), .pair_lo(pair_lo), .pair_hi(pair_hi), .imm6(imm6),
    .res(res), .res_we(res_we), .res_hi_byte(res_hi_byte), .busy(busy),
    .flag_upd(flag_upd), .flag_new(flag_new), .sreg(sreg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'd0, 5'd1, 5'd2, 5'd10: return "R2";
      5'd4, 5'd5: return "R3";
      5'd3: return "R4";
      5'd6, 5'd7, 5'd8: return "R5";
      5'd9, 5'd11, 5'd12: return "R6";
      5'd13, 5'd14, 5'd15, 5'd16, 5'd17: return "R7";
      5'd18: return "R8";
      5'd19, 5'd20, 5'd21: return "R10";
      default: return "R1";
    endcase
  endfunction

  // reference model computed from the requirement text
  function automatic void model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
      input logic [2:0] bs, input logic [7:0] old, output logic [7:0] r, output logic we,
      output logic [7:0] m, output logic [7:0] nw);
    int ai, bi, ci, s, sa, sb;
    logic [7:0] f;
    f = old; r = 8'h00; we = 1'b0; m = 8'h00;
    ai = int'(a); bi = int'(b); ci = 0;
    if (op == 5'd10) begin bi = ai; ai = 0; end
    if (op == 5'd1 || op == 5'd3 || op == 5'd5) ci = old[0] ? 1 : 0;
    sa = (ai > 127) ? ai - 256 : ai;
    sb = (bi > 127) ? bi - 256 : bi;
    case (op)
      5'd0, 5'd1: begin
        s = ai + bi + ci; r = 8'(s); f[0] = (s > 255);
        f[5] = ((ai % 16) + (bi % 16) + ci) > 15;
        s = sa + sb + ci; f[3] = (s > 127) || (s < -128);
        we = 1'b1; m = 8'h3F;
      end
      5'd2, 5'd3, 5'd4, 5'd5, 5'd10: begin
        s = ai - bi - ci; r = 8'(s); f[0] = (s < 0);
        f[5] = ((ai % 16) - (bi % 16) - ci) < 0;
        s = sa - sb - ci; f[3] = (s > 127) || (s < -128);
        we = (op != 5'd4) && (op != 5'd5); m = 8'h3F;
      end
      5'd6: begin r = a & b; f[3] = 1'b0; we = 1'b1; m = 8'h1E; end
      5'd7: begin r = a | b; f[3] = 1'b0; we = 1'b1; m = 8'h1E; end
      5'd8: begin r = a ^ b; f[3] = 1'b0; we = 1'b1; m = 8'h1E; end
      5'd9: begin r = 8'(255 - ai); f[0] = 1'b1; f[3] = 1'b0; we = 1'b1; m = 8'h1F; end
      5'd11: begin r = 8'(ai + 1); f[3] = (ai == 127); we = 1'b1; m = 8'h1E; end
      5'd12: begin r = 8'(ai - 1); f[3] = (ai == 128); we = 1'b1; m = 8'h1E; end
      5'd13: begin r = 8'(ai * 2); f[0] = a[7]; f[3] = r[7] ^ f[0]; we = 1'b1; m = 8'h1F; end
      5'd14: begin r = 8'(ai / 2); f[0] = a[0]; f[3] = r[7] ^ f[0]; we = 1'b1; m = 8'h1F; end
      5'd15: begin r = 8'(ai * 2 + (old[0] ? 1 : 0)); f[0] = a[7]; f[3] = r[7] ^ f[0];
                   we = 1'b1; m = 8'h1F; end
      5'd16: begin r = 8'(ai / 2 + (old[0] ? 128 : 0)); f[0] = a[0]; f[3] = r[7] ^ f[0];
                   we = 1'b1; m = 8'h1F; end
      5'd17: begin r = 8'(ai / 2 + (a[7] ? 128 : 0)); f[0] = a[0]; f[3] = r[7] ^ f[0];
                   we = 1'b1; m = 8'h1F; end
      5'd18: begin r = 8'((ai % 16) * 16 + ai / 16); we = 1'b1; end
      5'd19: begin f[bs] = 1'b1; m[bs] = 1'b1; end
      5'd20: begin f[bs] = 1'b0; m[bs] = 1'b1; end
      5'd21: begin f[6] = a[bs]; m[6] = 1'b1; end
      default: begin end
    endcase
    if (op <= 5'd18) begin
      f[1] = (r == 8'h00);
      if (op == 5'd3 || op == 5'd5) f[1] = f[1] && old[1];
      f[2] = r[7];
      f[4] = f[2] ^ f[3];
    end
    nw = (old & ~m) | (f & m);
  endfunction

  // entered at a falling edge, returns at the next falling edge
  task automatic do_op(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] bs);
    logic [7:0] e_r, e_m, e_n;
    logic e_we;
    string t;
    model(op, a, b, bs, exp_sreg, e_r, e_we, e_m, e_n);
    t = tag_of(op);
    op_valid = 1'b1; op_sel = op; opa = a; opb = b; bit_sel = bs;
    #5;
    chk(res_we == e_we && (!e_we || res == e_r) && flag_upd == e_m && flag_new == e_n,
        t, {7'd0, res_we, flag_upd, flag_new, res}, {7'd0, e_we, e_m, e_n, e_r});
    @(negedge clk);
    op_valid = 1'b0;
    chk(sreg == e_n, "R13", {24'd0, sreg}, {24'd0, e_n});
    if (e_m[4] && e_m[2])
      chk(sreg[4] == (sreg[2] ^ sreg[3]), "R9", {24'd0, sreg}, {24'd0, e_n});
    exp_sreg = e_n;
  endtask

  task automatic do_word(input bit sub, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [5:0] k);
    int v, s, sv, t;
    logic [15:0] rr;
    logic [7:0] e_n;
    v = int'({hi, lo});
    s = sub ? v - int'(k) : v + int'(k);
    rr = 16'(s);
    sv = (v > 32767) ? v - 65536 : v;
    t = sub ? sv - int'(k) : sv + int'(k);
    e_n = exp_sreg;
    e_n[0] = sub ? (s < 0) : (s > 65535);
    e_n[1] = (rr == 16'h0000);
    e_n[2] = rr[15];
    e_n[3] = (t > 32767) || (t < -32768);
    e_n[4] = e_n[2] ^ e_n[3];
    op_valid = 1'b1; op_sel = sub ? 5'd23 : 5'd22;
    pair_lo = lo; pair_hi = hi; imm6 = k;
    #5;
    chk(res_we && !res_hi_byte && !busy && flag_upd == 8'h00 && res == rr[7:0], "R11",
        {20'd0, res_we, res_hi_byte, busy, flag_upd, res}, {20'd0, 3'b100, 8'h00, rr[7:0]});
    @(negedge clk);
    // request during the second cycle must be ignored: set interrupt bit
    op_valid = 1'b1; op_sel = 5'd19; bit_sel = 3'd7;
    pair_lo = ~lo; pair_hi = ~hi;
    #5;
    chk(busy && res_we && res_hi_byte && flag_upd == 8'h1F && res == rr[15:8] &&
        flag_new == e_n, "R11",
        {7'd0, busy, res_we, res_hi_byte, flag_upd, flag_new, res[5:0]},
        {7'd0, 3'b111, 8'h1F, e_n, rr[13:8]});
    @(negedge clk);
    op_valid = 1'b0;
    chk(sreg == e_n && !busy, "R12", {23'd0, busy, sreg}, {24'd0, e_n});
    exp_sreg = e_n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_sel = 5'd0; opa = 8'h00; opb = 8'h00;
    bit_sel = 3'd0; pair_lo = 8'h00; pair_hi = 8'h00; imm6 = 6'd0;
    exp_sreg = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(sreg == 8'h00 && !busy && !res_we, "R1", {22'd0, busy, res_we, sreg},
        32'd0);

    // R1: spare codes do nothing
    for (int c = 24; c < 32; c++) do_op(5'(c), 8'hFF, 8'h01, 3'd0);

    // R10: single-flag writes and T copy
    for (int i = 0; i < 8; i++) begin
      do_op(5'd19, 8'h00, 8'h00, 3'(i));
      do_op(5'd21, 8'h5A, 8'h00, 3'(i));
      do_op(5'd20, 8'h00, 8'h00, 3'(i));
      do_op(5'd21, 8'hA5, 8'h00, 3'(i));
      do_op(5'd19, 8'h00, 8'h00, 3'((i * 3) % 8));
    end

    // R2 R3 R4: arithmetic sweep with varying carry and zero
    for (int k = 0; k < 7; k++) begin
      for (int a = 0; a < 256; a += 3) begin
        for (int j = 0; j < 20; j++) begin
          if ((a + j) % 4 == 0) do_op(((a + j) % 8 == 0) ? 5'd19 : 5'd20, 8'h00, 8'h00, 3'd0);
          if (j % 5 == 0) do_op((a % 2 == 0) ? 5'd19 : 5'd20, 8'h00, 8'h00, 3'd1);
          do_op((k == 6) ? 5'd10 : 5'(k), 8'(a), BL[j], 3'd0);
        end
      end
    end

    // R4: equal bytes keep a cleared Z across a chained compare
    do_op(5'd20, 8'h00, 8'h00, 3'd1);
    do_op(5'd20, 8'h00, 8'h00, 3'd0);
    do_op(5'd5, 8'h42, 8'h42, 3'd0);
    chk(sreg[1] == 1'b0, "R4", {31'd0, sreg[1]}, 32'd0);

    // R5: logic operations
    for (int k = 6; k < 9; k++) begin
      for (int a = 0; a < 256; a++) begin
        for (int j = 0; j < 20; j += 3) begin
          if (j == 0) do_op(a[0] ? 5'd19 : 5'd20, 8'h00, 8'h00, 3'd0);
          do_op(5'(k), 8'(a), BL[j], 3'd0);
        end
      end
    end

    // R6 R7 R8: unary operations, every operand, both carry values
    for (int k = 9; k < 19; k++) begin
      if (k == 10) continue;
      for (int a = 0; a < 256; a++) begin
        for (int c = 0; c < 2; c++) begin
          do_op((c == 1) ? 5'd19 : 5'd20, 8'h00, 8'h00, 3'd0);
          do_op(5'(k), 8'(a), 8'h00, 3'd0);
        end
      end
    end

    // R11 R12: word add and subtract
    begin
      logic [7:0] hl [5];
      logic [7:0] ll [6];
      logic [5:0] kl [4];
      hl = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h12};
      ll = '{8'h00, 8'h01, 8'h3F, 8'hC1, 8'hFF, 8'hFE};
      kl = '{6'd0, 6'd1, 6'd63, 6'd32};
      for (int s = 0; s < 2; s++)
        for (int h = 0; h < 5; h++)
          for (int l = 0; l < 6; l++)
            for (int q = 0; q < 4; q++) begin
              do_op(5'd20, 8'h00, 8'h00, 3'd7);
              do_word(s == 1, ll[l], hl[h], kl[q]);
            end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule